// File: doc/BRIEF.md
# Oracle-Guided Local/Remote Placement Controller

This block makes the placement decisions for a group of four cores, each with a private 8-way L2 cache, where spare capacity is shared between the caches. Each core is marked in a mask as either a Spiller, which gains from extra capacity, or a Receiver, which can give capacity away. Every cached block and every arriving line comes with a next-use distance read from a preloaded table of future accesses. The all-ones distance means that the line is never referenced again. The tag and data arrays, the coherence bus and the future-access table are outside the block. They appear here only as input vectors that describe the local set and the matching set in every peer cache.

When a Spiller misses, the block decides where the arriving line goes at the moment it arrives. The line is either installed locally, which displaces one local way, or it is sent directly to a Receiver cache and never enters the local L2. The block also picks the slot in that Receiver cache that receives the displaced block. When a Spiller hits in a remote cache, the block decides whether to swap the remote line with a local one. Writebacks from the L1 merge into the line wherever it is on chip. The block accepts one request at a time under a valid/ready handshake. After a fixed latency that depends on the kind of access, it pulses a done strobe together with the held decision.

Top module: `oracle_place_ctrl`

## Requirements
- R1: While and directly after reset, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until `done` has been pulsed, so only one request is ever outstanding.
- R3: `done` is high for the single cycle that follows the Nth clock edge after the accepting edge. N is 7 for a local hit (`req_kind`=0), 250 for a miss (1) and 50 for a remote hit (2). For an L1 writeback (3), N is 50 when `req_loc`=2 (line held in a peer cache) and 7 otherwise.
- R4: On a miss by a Spiller core while at least one Receiver exists, the victim is the candidate with the largest distance among local ways 0..7 (way i at `local_dist[i*8 +: 8]`) and the arriving line. Ties go to the lowest way index, and the arriving line ranks after way 7. If the victim is a local way, `install_local`=1, `local_way` names it and `spill`=1. Two ways that both hold the all-ones distance tie like any other equal values.
- R5: If the arriving line is strictly farther than every local way in an R4 miss, then `install_local`=0 and `spill`=1, so the line goes remote and is never installed locally.
- R6: For every spill, `rem_cache` names a Receiver core (its bit in `spiller_mask` is 0). The first cache examined is chosen by a 16-bit LFSR that reloads from `seed_val` when `seed_load` is high. The same seed, followed by the same request timing, gives the same choice.
- R7: If the LRU way of the examined Receiver's target set (its index at `rcv_lru[c*3 +: 3]`, its owner at `rcv_own[(c*8+w)*2 +: 2]`) is owned by a Receiver core, then `rem_over_spiller`=0 and `rem_way` is that LRU way.
- R8: If that LRU way is owned by a Spiller S, then `rem_over_spiller`=1. The slot is the block of S with the largest distance (`rcv_dist[(c*8+w)*8 +: 8]`) across the target sets of all Receiver caches. Ties go to the lowest cache index, then the lowest way index.
- R9: On a remote hit by a Spiller, if some local way is at least as far as the remote line, then `swap`=1 and `local_way` is the farthest local way (lowest index on ties). Otherwise `swap`=0 and the line stays remote.
- R10: A miss by a Receiver core, or by a Spiller when no Receiver exists, sets `install_local`=1, `local_way`=`local_lru` and `spill`=0. A remote hit by a Receiver sets `swap`=0.
- R11: For an L1 writeback with `req_loc` of 1 or 2 (line on chip), `wb_merge`=1 and `install_local`=0. With `req_loc`=0 (line absent everywhere), `wb_merge`=0, `install_local`=1 and `local_way`=`local_lru`.
- R12: `l1_fill` is 1 together with `done` for every kind except writeback. A local hit sets no placement action. `done` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Reload the random generator from `seed_val` |
| seed_val | input | 16 | LFSR seed (a zero seed loads 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_kind | input | 2 | 0 local hit, 1 miss, 2 remote hit, 3 L1 writeback |
| req_core | input | 2 | Requesting core |
| req_loc | input | 2 | Writeback line location: 0 absent, 1 local, 2 peer |
| spiller_mask | input | 4 | Bit c set when core c is a Spiller |
| local_dist | input | 64 | Next-use distance of the 8 local ways |
| local_lru | input | 3 | LRU way of the local set |
| line_dist | input | 8 | Distance of the arriving or remotely hit line |
| rcv_own | input | 64 | Owning core of each way of each peer target set |
| rcv_dist | input | 256 | Distance of each way of each peer target set |
| rcv_lru | input | 12 | LRU way of each peer target set |
| done | output | 1 | Completion strobe |
| l1_fill | output | 1 | Requested data goes to the core and its L1 |
| install_local | output | 1 | Write a line into `local_way` |
| local_way | output | 3 | Local way installed or swapped |
| spill | output | 1 | A block is placed into a Receiver cache |
| rem_cache | output | 2 | Receiver cache getting the spilled block |
| rem_way | output | 3 | Way overwritten in that cache |
| rem_over_spiller | output | 1 | The overwritten block belongs to a Spiller |
| swap | output | 1 | Exchange the remote hit line with `local_way` |
| wb_merge | output | 1 | Writeback merges into an existing on-chip line |

## Verification
The assertions assume that the request fields stay stable from the rise of `req_valid` until the accepting edge. They also assume that every owner code names one of the four cores and that every LRU pointer is a real way. The selection checks further assume that a Spiller's blocks can appear in a Receiver's set only through the owner vector. The bench changes all inputs only on the falling edge and holds them until the transaction completes. It draws owners, LRU pointers and distances only from legal ranges. Distances are often squeezed into a small range, which forces ties, and the no-future-use value is mixed in. Because the random Receiver choice is not predicted, the bench checks the chosen slot against the properties that any legal choice must meet.

// File: rtl/plc_pkg.sv
package plc_pkg;
    localparam int NCORE  = 4;
    localparam int NWAY   = 8;
    localparam int DW     = 8;
    localparam int LFSR_W = 16;
    localparam int CW     = $clog2(NCORE);
    localparam int WW     = $clog2(NWAY);

    typedef enum logic [1:0] {
        K_LHIT = 2'd0,
        K_MISS = 2'd1,
        K_RHIT = 2'd2,
        K_WB   = 2'd3
    } kind_e;

    localparam logic [1:0] LOC_NONE   = 2'd0;
    localparam logic [1:0] LOC_REMOTE = 2'd2;

    typedef struct packed {
        logic          l1_fill;
        logic          install_local;
        logic [WW-1:0] local_way;
        logic          spill;
        logic [CW-1:0] rem_cache;
        logic [WW-1:0] rem_way;
        logic          rem_over_spiller;
        logic          swap;
        logic          wb_merge;
    } decision_t;

    // Farthest next use among the local ways; the lowest index wins a tie.
    function automatic logic [WW-1:0] farthest_way(input logic [NWAY*DW-1:0] d);
        logic [DW-1:0] best;
        logic [WW-1:0] idx;
        best = d[DW-1:0];
        idx  = '0;
        for (int i = 1; i < NWAY; i++) begin
            if (d[i*DW +: DW] > best) begin
                best = d[i*DW +: DW];
                idx  = WW'(i);
            end
        end
        return idx;
    endfunction
endpackage

// File: rtl/plc_lfsr.sv
module plc_lfsr
    import plc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    output logic [LFSR_W-1:0] state
);
    logic fb;
    assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

    always_ff @(posedge clk) begin
        if (rst)
            state <= 16'hACE1;
        else if (load)
            state <= (seed == '0) ? 16'h0001 : seed;
        else
            state <= {state[LFSR_W-2:0], fb};
    end

    p_lfsr_alive_r6: assert property (@(posedge clk) disable iff (rst)
        state != '0);
endmodule

// File: rtl/plc_victim_sel.sv
module plc_victim_sel
    import plc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_en,
    input  logic [NWAY*DW-1:0] local_dist,
    input  logic [DW-1:0]      line_dist,
    output logic [WW-1:0]      far_way,
    output logic               line_farthest
);
    logic [DW-1:0] far_dist;

    always_comb far_way = farthest_way(local_dist);
    assign far_dist      = local_dist[int'(far_way)*DW +: DW];
    assign line_farthest = line_dist > far_dist;

    p_far_bounds_r4: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (far_dist >= local_dist[DW-1:0]) &&
                   (far_dist >= local_dist[(NWAY-1)*DW +: DW]));
    p_tie_low_r4: assert property (@(posedge clk) disable iff (rst)
        (chk_en && far_way != '0) |-> far_dist > local_dist[DW-1:0]);
endmodule

// File: rtl/plc_remote_slot.sv
module plc_remote_slot
    import plc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     chk_en,
    input  logic [CW-1:0]            start,
    input  logic [NCORE-1:0]         spiller_mask,
    input  logic [NCORE*NWAY*CW-1:0] rcv_own,
    input  logic [NCORE*NWAY*DW-1:0] rcv_dist,
    input  logic [NCORE*WW-1:0]      rcv_lru,
    output logic                     any_rcv,
    output logic [CW-1:0]            slot_cache,
    output logic [WW-1:0]            slot_way,
    output logic                     over_spiller
);
    logic [NCORE-1:0] rcv_mask;
    logic [CW-1:0]    lru_owner [NCORE];
    logic [CW-1:0]    pick, cand, vict_owner, own_cw;
    logic             found, hit;
    logic [DW-1:0]    best_d, cur_d;
    logic [CW-1:0]    best_c;
    logic [WW-1:0]    best_w;

    assign rcv_mask = ~spiller_mask;
    assign any_rcv  = |rcv_mask;

    for (genvar g = 0; g < NCORE; g++) begin : g_lru
        logic [WW-1:0] lw;
        assign lw           = rcv_lru[g*WW +: WW];
        assign lru_owner[g] = rcv_own[(g*NWAY + int'(lw))*CW +: CW];
    end

    // Step one: rotate from the random start to the first Receiver.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        cand  = '0;
        for (int k = 0; k < NCORE; k++) begin
            cand = start + CW'(k);
            if (!found && rcv_mask[cand]) begin
                pick  = cand;
                found = 1'b1;
            end
        end
    end

    assign vict_owner = lru_owner[pick];

    // Step two: farthest block of that Spiller over every Receiver set.
    always_comb begin
        hit    = 1'b0;
        best_d = '0;
        best_c = '0;
        best_w = '0;
        own_cw = '0;
        cur_d  = '0;
        for (int c = 0; c < NCORE; c++) begin
            for (int w = 0; w < NWAY; w++) begin
                own_cw = rcv_own[(c*NWAY + w)*CW +: CW];
                cur_d  = rcv_dist[(c*NWAY + w)*DW +: DW];
                if (rcv_mask[c] && own_cw == vict_owner && (!hit || cur_d > best_d)) begin
                    hit    = 1'b1;
                    best_d = cur_d;
                    best_c = CW'(c);
                    best_w = WW'(w);
                end
            end
        end
    end

    assign over_spiller = any_rcv && spiller_mask[vict_owner];
    assign slot_cache   = over_spiller ? best_c : pick;
    assign slot_way     = over_spiller ? best_w : rcv_lru[int'(pick)*WW +: WW];

    p_slot_receiver_r6: assert property (@(posedge clk) disable iff (rst)
        (chk_en && any_rcv) |-> !spiller_mask[slot_cache]);
    p_slot_owner_r8: assert property (@(posedge clk) disable iff (rst)
        (chk_en && over_spiller) |->
            rcv_own[(int'(slot_cache)*NWAY + int'(slot_way))*CW +: CW] == vict_owner);
    p_slot_rcv_owned_r7: assert property (@(posedge clk) disable iff (rst)
        (chk_en && any_rcv && !over_spiller) |->
            !spiller_mask[rcv_own[(int'(slot_cache)*NWAY + int'(slot_way))*CW +: CW]]);
endmodule

// File: rtl/oracle_place_ctrl.sv
module oracle_place_ctrl
    import plc_pkg::*;
#(
    parameter int LAT_LOCAL  = 7,
    parameter int LAT_REMOTE = 50,
    parameter int LAT_MISS   = 250
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     seed_load,
    input  logic [LFSR_W-1:0]        seed_val,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_kind,
    input  logic [CW-1:0]            req_core,
    input  logic [1:0]               req_loc,
    input  logic [NCORE-1:0]         spiller_mask,
    input  logic [NWAY*DW-1:0]       local_dist,
    input  logic [WW-1:0]            local_lru,
    input  logic [DW-1:0]            line_dist,
    input  logic [NCORE*NWAY*CW-1:0] rcv_own,
    input  logic [NCORE*NWAY*DW-1:0] rcv_dist,
    input  logic [NCORE*WW-1:0]      rcv_lru,
    output logic                     done,
    output logic                     l1_fill,
    output logic                     install_local,
    output logic [WW-1:0]            local_way,
    output logic                     spill,
    output logic [CW-1:0]            rem_cache,
    output logic [WW-1:0]            rem_way,
    output logic                     rem_over_spiller,
    output logic                     swap,
    output logic                     wb_merge
);
    localparam int LCW = $clog2(LAT_MISS + 1);

    kind_e            kind;
    logic             accept, busy, req_is_spl;
    logic [LCW-1:0]   cnt, lat_d, lat_q, since_acc;
    logic [LFSR_W-1:0] rnd;
    logic [WW-1:0]    far_way, slot_way;
    logic             line_far, any_rcv, over_spl;
    logic [CW-1:0]    slot_cache;
    logic [NCORE-1:0] mask_q;
    decision_t        dec_d, dec_q;

    assign kind       = kind_e'(req_kind);
    assign req_ready  = !busy;
    assign accept     = req_valid && req_ready;
    assign req_is_spl = spiller_mask[req_core];

    plc_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (seed_load),
        .seed  (seed_val),
        .state (rnd)
    );

    plc_victim_sel u_victim (
        .clk           (clk),
        .rst           (rst),
        .chk_en        (accept),
        .local_dist    (local_dist),
        .line_dist     (line_dist),
        .far_way       (far_way),
        .line_farthest (line_far)
    );

    plc_remote_slot u_slot (
        .clk          (clk),
        .rst          (rst),
        .chk_en       (accept),
        .start        (rnd[CW-1:0]),
        .spiller_mask (spiller_mask),
        .rcv_own      (rcv_own),
        .rcv_dist     (rcv_dist),
        .rcv_lru      (rcv_lru),
        .any_rcv      (any_rcv),
        .slot_cache   (slot_cache),
        .slot_way     (slot_way),
        .over_spiller (over_spl)
    );

    always_comb begin
        dec_d = '0;
        lat_d = LCW'(LAT_LOCAL);
        unique case (kind)
            K_LHIT: dec_d.l1_fill = 1'b1;
            K_MISS: begin
                dec_d.l1_fill = 1'b1;
                lat_d         = LCW'(LAT_MISS);
                if (req_is_spl && any_rcv) begin
                    dec_d.spill            = 1'b1;
                    dec_d.rem_cache        = slot_cache;
                    dec_d.rem_way          = slot_way;
                    dec_d.rem_over_spiller = over_spl;
                    if (!line_far) begin
                        dec_d.install_local = 1'b1;
                        dec_d.local_way     = far_way;
                    end
                end else begin
                    dec_d.install_local = 1'b1;
                    dec_d.local_way     = local_lru;
                end
            end
            K_RHIT: begin
                dec_d.l1_fill = 1'b1;
                lat_d         = LCW'(LAT_REMOTE);
                if (req_is_spl && !line_far) begin
                    dec_d.swap      = 1'b1;
                    dec_d.local_way = far_way;
                end
            end
            K_WB: begin
                if (req_loc == LOC_NONE) begin
                    dec_d.install_local = 1'b1;
                    dec_d.local_way     = local_lru;
                end else begin
                    dec_d.wb_merge = 1'b1;
                    if (req_loc == LOC_REMOTE) lat_d = LCW'(LAT_REMOTE);
                end
            end
            default: dec_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            lat_q  <= '0;
            dec_q  <= '0;
            mask_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                cnt    <= lat_d - LCW'(1);
                lat_q  <= lat_d;
                dec_q  <= dec_d;
                mask_q <= spiller_mask;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - LCW'(1);
                end
            end
        end
    end

    assign l1_fill          = dec_q.l1_fill;
    assign install_local    = dec_q.install_local;
    assign local_way        = dec_q.local_way;
    assign spill            = dec_q.spill;
    assign rem_cache        = dec_q.rem_cache;
    assign rem_way          = dec_q.rem_way;
    assign rem_over_spiller = dec_q.rem_over_spiller;
    assign swap             = dec_q.swap;
    assign wb_merge         = dec_q.wb_merge;

    // Checker counter: edges elapsed since the accepting edge.
    always_ff @(posedge clk) begin
        if (rst)
            since_acc <= '0;
        else if (accept)
            since_acc <= '0;
        else if (busy)
            since_acc <= since_acc + LCW'(1);
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> since_acc == lat_q);
    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!req_ready && !done));
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_wb_action_r11: assert property (@(posedge clk) disable iff (rst)
        (done && !l1_fill) |-> (wb_merge != install_local));
    p_spill_dest_r6: assert property (@(posedge clk) disable iff (rst)
        (done && spill) |-> !mask_q[rem_cache]);
endmodule

// File: tb/tb_oracle_place_ctrl.sv
module tb_oracle_place_ctrl;
    import plc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        seed_load = 1'b0;
    logic [15:0] seed_val  = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind  = '0;
    logic [1:0]  req_core  = '0;
    logic [1:0]  req_loc   = '0;
    logic [3:0]  spiller_mask = '0;
    logic [7:0]  ld [NWAY];
    logic [7:0]  line_d = '0;
    logic [2:0]  llru = '0;
    logic [1:0]  own [NCORE][NWAY];
    logic [7:0]  rd  [NCORE][NWAY];
    logic [2:0]  rlru [NCORE];

    logic [NWAY*DW-1:0]       local_dist_f;
    logic [NCORE*NWAY*CW-1:0] own_f;
    logic [NCORE*NWAY*DW-1:0] rd_f;
    logic [NCORE*WW-1:0]      rlru_f;

    always_comb begin
        for (int i = 0; i < NWAY; i++) local_dist_f[i*DW +: DW] = ld[i];
        for (int c = 0; c < NCORE; c++) begin
            rlru_f[c*WW +: WW] = rlru[c];
            for (int w = 0; w < NWAY; w++) begin
                own_f[(c*NWAY+w)*CW +: CW] = own[c][w];
                rd_f[(c*NWAY+w)*DW +: DW]  = rd[c][w];
            end
        end
    end

    logic done, l1_fill, install_local, spill, rem_over_spiller, swap, wb_merge;
    logic [2:0] local_way, rem_way;
    logic [1:0] rem_cache;

    oracle_place_ctrl dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_core(req_core), .req_loc(req_loc), .spiller_mask(spiller_mask),
        .local_dist(local_dist_f), .local_lru(llru), .line_dist(line_d),
        .rcv_own(own_f), .rcv_dist(rd_f), .rcv_lru(rlru_f),
        .done(done), .l1_fill(l1_fill), .install_local(install_local),
        .local_way(local_way), .spill(spill), .rem_cache(rem_cache),
        .rem_way(rem_way), .rem_over_spiller(rem_over_spiller),
        .swap(swap), .wb_merge(wb_merge)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int far_idx();
        int b = 0;
        for (int i = 1; i < NWAY; i++) if (ld[i] > ld[b]) b = i;
        return b;
    endfunction

    // Expected slot for a Spiller's blocks across all Receiver sets (R8).
    function automatic int ref_slot(input int s);
        int bc = -1, bw = 0, best = 0;
        for (int c = 0; c < NCORE; c++)
            for (int w = 0; w < NWAY; w++)
                if (!spiller_mask[c] && own[c][w] == s[1:0] &&
                    (bc < 0 || int'(rd[c][w]) > best)) begin
                    bc = c; bw = w; best = rd[c][w];
                end
        return bc * NWAY + bw;
    endfunction

    function automatic int exp_lat();
        case (req_kind)
            2'd1:    return 250;
            2'd2:    return 50;
            2'd3:    return (req_loc == 2'd2) ? 50 : 7;
            default: return 7;
        endcase
    endfunction

    task automatic check_remote();
        int s, exists;
        chk("R6 rem_cache is a Receiver", spiller_mask[rem_cache], 0);
        if (!rem_over_spiller) begin
            chk("R7 rem_way is LRU of chosen Receiver", rem_way, rlru[rem_cache]);
            chk("R7 LRU owner is a Receiver", spiller_mask[own[rem_cache][rlru[rem_cache]]], 0);
        end else begin
            s = own[rem_cache][rem_way];
            exists = 0;
            for (int c = 0; c < NCORE; c++)
                if (!spiller_mask[c] && own[c][rlru[c]] == s[1:0]) exists = 1;
            chk("R8 slot owner is a Spiller", spiller_mask[s], 1);
            chk("R8 owner holds a Receiver LRU way", exists, 1);
            chk("R8 farthest block of that Spiller", rem_cache * NWAY + rem_way, ref_slot(s));
        end
    endtask

    task automatic run_txn();
        int n, lat, fw, mx;
        bit got, spl, anyr;
        lat = exp_lat();
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ready low while busy", req_ready, 0);
        n = 0;
        got = 1'b0;
        while (!got && n < 1000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            got = done;
        end
        chk("R3 done latency", n, lat);
        chk("R12 l1_fill", l1_fill, (req_kind != 2'd3) ? 1 : 0);
        fw = far_idx();
        mx = ld[fw];
        spl = spiller_mask[req_core];
        anyr = (spiller_mask != 4'hF);
        case (req_kind)
            2'd0: begin
                chk("R12 local hit takes no action",
                    {install_local, spill, swap, wb_merge}, 0);
            end
            2'd1: begin
                if (spl && anyr) begin
                    chk("R4 spill on Spiller miss", spill, 1);
                    if (int'(line_d) > mx) begin
                        chk("R5 bypass local install", install_local, 0);
                    end else begin
                        chk("R4 install locally", install_local, 1);
                        chk("R4 victim way", local_way, fw);
                    end
                    check_remote();
                end else begin
                    chk("R10 local LRU install", {install_local, spill}, 2);
                    chk("R10 local LRU way", local_way, llru);
                end
            end
            2'd2: begin
                if (spl && int'(line_d) <= mx) begin
                    chk("R9 swap", swap, 1);
                    chk("R9 swap way", local_way, fw);
                end else begin
                    chk("R9 R10 line left in place", swap, 0);
                end
            end
            default: begin
                if (req_loc == 2'd0) begin
                    chk("R11 allocate on absent writeback", {wb_merge, install_local}, 1);
                    chk("R11 allocate way", local_way, llru);
                end else begin
                    chk("R11 merge on-chip writeback", {wb_merge, install_local}, 2);
                end
            end
        endcase
        @(posedge clk);
        @(negedge clk);
        chk("R12 done single cycle", done, 0);
    endtask

    task automatic gen_random();
        int mode;
        mode = $urandom_range(0, 2);
        req_kind = 2'($urandom_range(0, 3));
        req_core = 2'($urandom_range(0, 3));
        req_loc  = 2'($urandom_range(0, 2));
        spiller_mask = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 3) != 0) spiller_mask[req_core] = 1'b1;
        llru = 3'($urandom_range(0, 7));
        for (int i = 0; i < NWAY; i++)
            ld[i] = (mode == 0) ? 8'($urandom_range(0, 3)) :
                    (mode == 1) ? 8'($urandom_range(0, 255)) :
                    (($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom_range(200, 255)));
        line_d = (mode == 0) ? 8'($urandom_range(0, 4)) : 8'($urandom_range(0, 255));
        for (int c = 0; c < NCORE; c++) begin
            rlru[c] = 3'($urandom_range(0, 7));
            for (int w = 0; w < NWAY; w++) begin
                own[c][w] = 2'($urandom_range(0, 3));
                rd[c][w]  = (mode == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom_range(0, 255));
            end
        end
    endtask

    task automatic reseed(input logic [15:0] s);
        @(negedge clk);
        seed_load = 1'b1;
        seed_val  = s;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int first_c;
        void'($urandom(32'd2024));
        gen_random();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in reset", req_ready, 1);
        chk("R1 done low in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 done low after reset", done, 0);

        // R3 R12 directed local hit
        req_kind = 2'd0;
        run_txn();

        // R4 all-ones tie: way 0 and arriving line both never reused
        req_kind = 2'd1; req_core = 2'd0; spiller_mask = 4'b0001;
        for (int i = 0; i < NWAY; i++) ld[i] = 8'hFF;
        line_d = 8'hFF;
        for (int c = 0; c < NCORE; c++) begin
            rlru[c] = 3'd2;
            for (int w = 0; w < NWAY; w++) own[c][w] = 2'(c);
        end
        run_txn();
        chk("R4 all-ones tie keeps line local", install_local, 1);

        // R5 arriving line strictly farthest
        for (int i = 0; i < NWAY; i++) ld[i] = 8'(i * 3);
        line_d = 8'd200;
        run_txn();
        chk("R7 Receiver-owned LRU slot", rem_over_spiller, 0);

        // R8 every Receiver LRU way owned by Spiller core 0
        for (int c = 1; c < NCORE; c++) begin
            own[c][2] = 2'd0; rd[c][2] = 8'd5;
            own[c][6] = 2'd0; rd[c][6] = 8'd90;
        end
        rd[3][6] = 8'd90;
        run_txn();
        chk("R8 Spiller-owned LRU slot", rem_over_spiller, 1);
        chk("R8 tie to lowest cache", rem_cache * NWAY + rem_way, 1 * NWAY + 6);

        // R10 Spiller with no Receiver installs by LRU
        spiller_mask = 4'hF; llru = 3'd5;
        run_txn();

        // R9 remote line farthest stays remote, then ties swap
        req_kind = 2'd2; spiller_mask = 4'b0001;
        line_d = 8'd250;
        run_txn();
        line_d = 8'd21;
        run_txn();

        // R11 writeback in all three locations
        req_kind = 2'd3;
        for (int l = 0; l < 3; l++) begin
            req_loc = 2'(l);
            run_txn();
        end

        // R6 same seed gives the same Receiver choice
        req_kind = 2'd1; spiller_mask = 4'b0001;
        for (int c = 0; c < NCORE; c++)
            for (int w = 0; w < NWAY; w++) own[c][w] = 2'(c);
        for (int s = 1; s < 6; s++) begin
            reseed(16'(s * 4099));
            run_txn();
            first_c = rem_cache;
            reseed(16'(s * 4099));
            run_txn();
            chk("R6 seed repeatability", rem_cache, first_c);
        end

        for (int t = 0; t < 160; t++) begin
            gen_random();
            run_txn();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule